// File: doc/BRIEF.md
# Programmable IR pulse-timing decoder

This block turns a demodulated infrared line into data words. Every symbol is one mark (active level) followed by one space (inactive level), and its end is the next mark edge. The block measures the mark length (pulse width) and the whole mark-plus-space length (period) in clock cycles. It compares both against min/max windows taken from configuration words. There is one window set for an optional leader symbol and four for data symbols. A data symbol that is accepted shifts one bit into an accumulator of up to 48 bits.

A message ends when the line stays in space for a programmable idle time. At that point the number of bits collected is checked against an even-rounded length window. A message that passes is captured into the data and length outputs with a one-cycle done strobe. A message that fails, or a symbol that no window accepts, gives a one-cycle error strobe instead and leaves the captured outputs untouched. The last mark of a frame acts as a stop mark: it opens a symbol that never completes and is not counted.

Top module: `ird_decoder`

## Requirements
- R1: While reset is held and on release, rx_done and rx_err are low and rx_data and rx_len are zero.
- R2: Each window word packs wmin in bits [7:0], wmax in [15:8], pdmin in [23:16] and pdmax in [31:24]. The leader window counts all four fields in units of 16 cycles. A data window counts the width fields in single cycles and the period fields in units of 2 cycles. A symbol is accepted only when its width and its period both lie inside the scaled window, bounds included. A symbol that fits no usable window pulses rx_err and drops the message.
- R3: ctrl bit 1 set means the first completed symbol of a message must match the leader window (ldr_win). Otherwise the message is dropped with rx_err. With bit 1 clear, the first symbol is read as data.
- R4: The first data bit of a message is decoded with s00 (dat_win[31:0], gives 0) and s01 (dat_win[63:32], gives 1). Every later bit uses s10 (dat_win[95:64], gives 0) and s11 (dat_win[127:96], gives 1). When both windows of a set fit, the 0 window wins.
- R5: ctrl bit 3 clear stores bit k of the message at rx_data[k]. With bit 3 set, each new bit enters at bit 0 and earlier bits move up, so the first bit ends at rx_data[len-1].
- R6: ctrl bit 4 set inverts every stored bit.
- R7: ctrl bit 2 set makes a low line level the mark level.
- R8: Let U be ft_cfg[9:0]. A message ends on the clock in which the space has lasted U*8 sampled cycles. A mark after U*8-1 space cycles still closes a symbol. rx_done or rx_err follows one cycle after the end.
- R9: The minimum length ft_cfg[15:10] is capped at 30 and rounded down to even. The maximum ft_cfg[21:16] is rounded up to even and capped at 48. A completed message whose bit count is outside this window pulses rx_err and updates nothing. A message in which no symbol completed ends silently.
- R10: While ctrl bit 0 is clear, the decoder idles, drops any partial message and gives no strobe.
- R11: An accepted data symbol beyond the 48th bit drops the message with rx_err. A 48-bit message can complete, and rx_len never exceeds 48.
- R12: rx_done and rx_err are never high together, and rx_data and rx_len change only in a cycle where rx_done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_line | input | 1 | Sampled, demodulated IR line |
| ctrl | input | 5 | bit0 decode enable, bit1 leader required, bit2 invert polarity, bit3 MSB-first, bit4 invert bits |
| ldr_win | input | 32 | Leader window (16-cycle units) |
| dat_win | input | 128 | Data windows s00, s01, s10, s11 from low to high word |
| ft_cfg | input | 22 | Idle units [9:0], min length [15:10], max length [21:16] |
| rx_data | output | 64 | Captured message bits |
| rx_len | output | 7 | Captured bit count |
| rx_done | output | 1 | One-cycle strobe for a captured message |
| rx_err | output | 1 | One-cycle strobe for a dropped message |

## Verification
The situations that are hardest to reach from the ports are the ones at the exact edge of a limit. One is a space that is one cycle short of the idle time and then ends in a mark. Another is a message one bit past the 48-bit accumulator or past the rounded length window. The bench builds whole frames symbol by symbol with chosen mark and space lengths, so each frame lands exactly on such an edge. A behavioural model in the bench, built on a bit queue, predicts every strobe and captured value, and the outputs are compared with it in every cycle. Directed frames also cover a symbol from the later data set used as the first bit, and decoding switched off in the middle of a message.

// File: rtl/ird_pkg.sv
package ird_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MARK  = 2'd1,
    ST_SPACE = 2'd2
  } ird_state_e;

  typedef struct packed {
    logic bit_inv;
    logic msb_first;
    logic pol_inv;
    logic lead_en;
    logic dec_en;
  } ird_ctrl_t;
endpackage

// File: rtl/ird_win.sv
module ird_win #(
  parameter int FW    = 8,
  parameter int CW    = 16,
  parameter int PD_SH = 1,
  parameter int W_SH  = 0
) (
  input  logic [4*FW-1:0] win,
  input  logic [CW-1:0]   width,
  input  logic [CW:0]     period,
  output logic            hit
);
  logic [CW:0] w_lo, w_hi, pd_lo, pd_hi;

  always_comb begin
    w_lo  = (CW+1)'(win[FW-1:0])      << W_SH;
    w_hi  = (CW+1)'(win[2*FW-1:FW])   << W_SH;
    pd_lo = (CW+1)'(win[3*FW-1:2*FW]) << PD_SH;
    pd_hi = (CW+1)'(win[4*FW-1:3*FW]) << PD_SH;
    hit   = ({1'b0, width} >= w_lo) && ({1'b0, width} <= w_hi) &&
            (period >= pd_lo) && (period <= pd_hi);
  end
endmodule

// File: rtl/ird_len_win.sv
module ird_len_win #(
  parameter int LW       = 6,
  parameter int LENW     = 7,
  parameter int MAX_BITS = 48,
  parameter int MIN_CAP  = 30
) (
  input  logic [LW-1:0]   min_raw,
  input  logic [LW-1:0]   max_raw,
  output logic [LENW-1:0] eff_min,
  output logic [LENW-1:0] eff_max
);
  logic [LENW-1:0] max_up;

  always_comb begin
    max_up = LENW'(max_raw) + LENW'(1);
    if (LENW'(min_raw) < LENW'(MIN_CAP)) eff_min = LENW'(min_raw) & ~LENW'(1);
    else                                 eff_min = LENW'(MIN_CAP);
    if (LENW'(max_raw) < LENW'(MAX_BITS)) eff_max = max_up & ~LENW'(1);
    else                                  eff_max = LENW'(MAX_BITS);
  end
endmodule

// File: rtl/ird_bit_acc.sv
module ird_bit_acc #(
  parameter int DW       = 64,
  parameter int MAX_BITS = 48,
  parameter int LENW     = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            shift,
  input  logic            bit_in,
  input  logic            msb_first,
  output logic [DW-1:0]   acc,
  output logic [LENW-1:0] cnt
);
  logic [DW-1:0]   acc_n;
  logic [LENW-1:0] cnt_n;

  always_comb begin
    acc_n = acc;
    cnt_n = cnt;
    if (clr) begin
      acc_n = '0;
      cnt_n = '0;
    end else if (shift) begin
      if (msb_first) begin
        acc_n = {acc[DW-2:0], bit_in};
      end else begin
        for (int i = 0; i < DW; i++)
          if (cnt == LENW'(i)) acc_n[i] = bit_in;
      end
      cnt_n = cnt + LENW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
    end else if (clr || shift) begin
      acc <= acc_n;
      cnt <= cnt_n;
    end
  end

  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LENW'(MAX_BITS));
endmodule

// File: rtl/ird_decoder.sv
module ird_decoder
  import ird_pkg::*;
#(
  parameter int FW       = 8,
  parameter int CW       = 16,
  parameter int FTW      = 10,
  parameter int LW       = 6,
  parameter int DW       = 64,
  parameter int MAX_BITS = 48,
  parameter int MIN_CAP  = 30
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ir_line,
  input  logic [4:0]                ctrl,
  input  logic [4*FW-1:0]           ldr_win,
  input  logic [16*FW-1:0]          dat_win,
  input  logic [FTW+2*LW-1:0]       ft_cfg,
  output logic [DW-1:0]             rx_data,
  output logic [$clog2(DW+1)-1:0]   rx_len,
  output logic                      rx_done,
  output logic                      rx_err
);
  localparam int WINW = 4 * FW;
  localparam int LENW = $clog2(DW + 1);
  localparam int NDAT = 4;

  ird_ctrl_t c;
  assign c = ird_ctrl_t'(ctrl);

  ird_state_e      state, st_n;
  logic [CW-1:0]   wcnt, wcnt_n, scnt, scnt_n, scnt_inc, idle_lim;
  logic [CW:0]     period;
  logic            act_now, act_q, lead_ok, lead_n, any_sym, any_n;
  logic            ldr_hit, b0hit, b1hit, need_ldr, first_bit, overflow;
  logic            acc_clr, acc_shift, bit_val, done_n, err_n;
  logic [NDAT-1:0] dhit;
  logic [DW-1:0]   acc;
  logic [LENW-1:0] acc_cnt, eff_min, eff_max;

  assign act_now  = ir_line ^ c.pol_inv;
  assign period   = {1'b0, wcnt} + {1'b0, scnt};
  assign scnt_inc = (scnt == '1) ? scnt : scnt + CW'(1);
  assign idle_lim = CW'({ft_cfg[FTW-1:0], 3'b000});

  ird_win #(.FW(FW), .CW(CW), .PD_SH(4), .W_SH(4)) u_ldr_win (
    .win(ldr_win), .width(wcnt), .period(period), .hit(ldr_hit));

  for (genvar g = 0; g < NDAT; g++) begin : g_dwin
    ird_win #(.FW(FW), .CW(CW), .PD_SH(1), .W_SH(0)) u_win (
      .win(dat_win[g*WINW +: WINW]), .width(wcnt), .period(period), .hit(dhit[g]));
  end

  ird_len_win #(.LW(LW), .LENW(LENW), .MAX_BITS(MAX_BITS), .MIN_CAP(MIN_CAP)) u_len (
    .min_raw(ft_cfg[FTW+LW-1:FTW]), .max_raw(ft_cfg[FTW+2*LW-1:FTW+LW]),
    .eff_min(eff_min), .eff_max(eff_max));

  ird_bit_acc #(.DW(DW), .MAX_BITS(MAX_BITS), .LENW(LENW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .shift(acc_shift), .bit_in(bit_val),
    .msb_first(c.msb_first), .acc(acc), .cnt(acc_cnt));

  assign first_bit = (acc_cnt == '0);
  assign b0hit     = first_bit ? dhit[0] : dhit[2];
  assign b1hit     = first_bit ? dhit[1] : dhit[3];
  assign need_ldr  = c.lead_en & ~lead_ok;
  assign overflow  = (acc_cnt == LENW'(MAX_BITS));
  assign bit_val   = ~b0hit ^ c.bit_inv;

  always_comb begin
    st_n = state; wcnt_n = wcnt; scnt_n = scnt; lead_n = lead_ok; any_n = any_sym;
    acc_clr = 1'b0; acc_shift = 1'b0; done_n = 1'b0; err_n = 1'b0;
    if (!c.dec_en) begin
      st_n = ST_IDLE; acc_clr = 1'b1; lead_n = 1'b0; any_n = 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          acc_clr = 1'b1; lead_n = 1'b0; any_n = 1'b0;
          if (act_now && !act_q) begin
            st_n = ST_MARK; wcnt_n = CW'(1); scnt_n = '0;
          end
        end
        ST_MARK: begin
          if (act_now) wcnt_n = (wcnt == '1) ? wcnt : wcnt + CW'(1);
          else begin
            st_n = ST_SPACE; scnt_n = CW'(1);
          end
        end
        ST_SPACE: begin
          if (act_now) begin
            if (need_ldr ? ldr_hit : ((b0hit | b1hit) && !overflow)) begin
              any_n = 1'b1;
              if (need_ldr) lead_n = 1'b1;
              else          acc_shift = 1'b1;
              st_n = ST_MARK; wcnt_n = CW'(1); scnt_n = '0;
            end else begin
              err_n = 1'b1; st_n = ST_IDLE;
            end
          end else begin
            scnt_n = scnt_inc;
            if (scnt_inc >= idle_lim) begin
              st_n = ST_IDLE;
              if (any_sym) begin
                if (acc_cnt >= eff_min && acc_cnt <= eff_max) done_n = 1'b1;
                else                                          err_n  = 1'b1;
              end
            end
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; wcnt <= '0; scnt <= '0; act_q <= 1'b0;
      lead_ok <= 1'b0; any_sym <= 1'b0; rx_done <= 1'b0; rx_err <= 1'b0;
    end else begin
      state <= st_n; wcnt <= wcnt_n; scnt <= scnt_n; act_q <= act_now;
      lead_ok <= lead_n; any_sym <= any_n; rx_done <= done_n; rx_err <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_len  <= '0;
    end else if (done_n) begin
      rx_data <= acc;
      rx_len  <= acc_cnt;
    end
  end

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_done && rx_err));
  // R12
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |-> ($stable(rx_data) && $stable(rx_len)));
  // R9
  len_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (rx_len >= $past(eff_min)) && (rx_len <= $past(eff_max)));
  // R10
  dis_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !c.dec_en |=> (state == ST_IDLE) && !rx_done && !rx_err);
  // R3
  lead_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_shift |-> (!c.lead_en || lead_ok));
endmodule

// File: tb/ird_decoder_tb.sv
module ird_decoder_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ir_line = 1'b0;
  logic [4:0]   ctrl = 5'b00011;
  logic [31:0]  ldr_win;
  logic [127:0] dat_win;
  logic [21:0]  ft_cfg;
  logic [63:0]  rx_data;
  logic [6:0]   rx_len;
  logic         rx_done, rx_err;

  int checks = 0, errors = 0;
  int got_done = 0, got_err = 0;
  logic [63:0] last_data = '0;
  logic [6:0]  last_len = '0;

  always #5 clk = ~clk;

  ird_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .ir_line(ir_line), .ctrl(ctrl), .ldr_win(ldr_win),
    .dat_win(dat_win), .ft_cfg(ft_cfg), .rx_data(rx_data), .rx_len(rx_len),
    .rx_done(rx_done), .rx_err(rx_err));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  m_ph, m_w, m_s;
  bit  m_aq, m_lead, m_any, e_done, e_err;
  bit  m_bits[$];
  logic [63:0] e_data;
  int  e_len;

  function automatic bit win_ok(logic [31:0] w, int psc, int wsc, int wd, int pd);
    return wd >= w[7:0]*wsc && wd <= w[15:8]*wsc && pd >= w[23:16]*psc && pd <= w[31:24]*psc;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_w = 0; m_s = 0; m_aq = 0; m_lead = 0; m_any = 0;
      e_done = 0; e_err = 0; e_data = '0; e_len = 0; m_bits.delete();
    end else begin
      bit act;
      act = ir_line ^ ctrl[2];
      e_done = 0; e_err = 0;
      if (!ctrl[0]) begin
        m_ph = 0; m_bits.delete(); m_lead = 0; m_any = 0;
      end else if (m_ph == 0) begin
        m_bits.delete(); m_lead = 0; m_any = 0;
        if (act && !m_aq) begin m_ph = 1; m_w = 1; m_s = 0; end
      end else if (m_ph == 1) begin
        if (act) begin if (m_w < 65535) m_w++; end
        else begin m_ph = 2; m_s = 1; end
      end else if (act) begin
        int p;
        bit h0, h1, fb;
        p = m_w + m_s;
        fb = (m_bits.size() == 0);
        h0 = win_ok(fb ? dat_win[31:0]  : dat_win[95:64],  2, 1, m_w, p);
        h1 = win_ok(fb ? dat_win[63:32] : dat_win[127:96], 2, 1, m_w, p);
        if (ctrl[1] && !m_lead) begin
          if (win_ok(ldr_win, 16, 16, m_w, p)) begin m_lead = 1; m_any = 1; m_ph = 1; m_w = 1; m_s = 0; end
          else begin e_err = 1; m_ph = 0; end
        end else if ((h0 || h1) && m_bits.size() < 48) begin
          m_bits.push_back(bit'(!h0) ^ ctrl[4]);
          m_any = 1; m_ph = 1; m_w = 1; m_s = 0;
        end else begin
          e_err = 1; m_ph = 0;
        end
      end else begin
        if (m_s < 65535) m_s++;
        if (m_s >= ft_cfg[9:0] * 8) begin
          int mn, mx, n;
          m_ph = 0;
          mn = ft_cfg[15:10]; mx = ft_cfg[21:16]; n = m_bits.size();
          mn = (mn < 30) ? (mn & ~1) : 30;
          mx = (mx < 48) ? ((mx + 1) & ~1) : 48;
          if (m_any) begin
            if (n >= mn && n <= mx) begin
              e_done = 1; e_len = n; e_data = '0;
              for (int k = 0; k < n; k++)
                if (ctrl[3]) e_data[n-1-k] = m_bits[k];
                else         e_data[k] = m_bits[k];
            end else e_err = 1;
          end
        end
      end
      m_aq = act;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(rx_done == e_done && rx_err == e_err, "R12 model strobes",
          {62'd0, rx_done, rx_err}, {62'd0, e_done, e_err});
      chk(rx_data == e_data && rx_len == 7'(e_len), "R2/R8 model capture", rx_data, e_data);
      if (rx_done) got_done++;
      if (rx_err)  got_err++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input bit a, input int n);
    ir_line = a ^ ctrl[2];
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_msg(input bit lead, input logic [63:0] v, input int n);
    if (lead) begin drive(1, 64); drive(0, 32); end
    for (int i = 0; i < n; i++) begin
      if (i == 0) begin if (v[i]) begin drive(1, 8);  drive(0, 34); end else begin drive(1, 8);  drive(0, 12); end end
      else        begin if (v[i]) begin drive(1, 16); drive(0, 30); end else begin drive(1, 16); drive(0, 12); end end
    end
  endtask

  task automatic stop_idle();
    drive(1, 8); drive(0, 100);
  endtask

  task automatic run_ok(input bit lead, input logic [63:0] v, input int n,
                        input logic [63:0] ev, input string tag);
    got_done = 0; got_err = 0;
    send_msg(lead, v, n); stop_idle();
    chk(got_done == 1 && got_err == 0, tag, 64'(got_done), 64'd1);
    chk(rx_data == ev, tag, rx_data, ev);
    chk(rx_len == 7'(n), tag, 64'(rx_len), 64'(n));
    last_data = rx_data; last_len = rx_len;
  endtask

  task automatic expect_bad(input string tag);
    chk(got_err >= 1 && got_done == 0, tag, 64'(got_err), 64'd1);
    chk(rx_data == last_data && rx_len == last_len, tag, rx_data, last_data);
  endtask

  function automatic logic [21:0] mk_ft(int mx, int mn, int u);
    return {6'(mx), 6'(mn), 10'(u)};
  endfunction

  initial begin
    #(150000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ldr_win = {8'd7, 8'd5, 8'd5, 8'd3};
    dat_win = {{8'd26, 8'd20, 8'd18, 8'd14}, {8'd16, 8'd12, 8'd18, 8'd14},
               {8'd24, 8'd18, 8'd10, 8'd6},  {8'd12, 8'd8,  8'd10, 8'd6}};
    ft_cfg  = mk_ft(63, 4, 10);
    repeat (3) @(posedge clk);
    #1;
    chk(rx_done == 0 && rx_err == 0 && rx_data == 0 && rx_len == 0, "R1 reset state", rx_data, 64'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(rx_done == 0 && rx_err == 0 && rx_data == 0, "R1 after release", rx_data, 64'd0);

    run_ok(1, 64'hA5, 8, 64'hA5, "R3 R4 leader frame lsb-first");
    ctrl = 5'b01011;
    run_ok(1, 64'h0F, 8, 64'hF0, "R5 msb-first order");
    ctrl = 5'b10011;
    run_ok(1, 64'h0F, 8, 64'hF0, "R6 bit inversion");
    ctrl = 5'b00111; ir_line = 1'b1;
    run_ok(1, 64'h3C, 8, 64'h3C, "R7 inverted polarity");
    ctrl = 5'b00001; ir_line = 1'b0;
    run_ok(0, 64'h1234, 16, 64'h1234, "R3 leader not required");
    run_ok(0, 64'h0000_ABCD_1234_5678, 48, 64'h0000_ABCD_1234_5678, "R11 full 48 bits");

    got_done = 0; got_err = 0;
    send_msg(0, 64'h1_0000_0000_0001, 49); stop_idle();
    expect_bad("R11 49th bit overflow");

    ctrl = 5'b00011;
    got_done = 0; got_err = 0;
    send_msg(0, 64'h5, 6); stop_idle();
    expect_bad("R3 missing leader");

    got_done = 0; got_err = 0;
    drive(1, 64); drive(0, 32); drive(1, 16); drive(0, 12); send_msg(0, 64'h3, 4); stop_idle();
    expect_bad("R4 later-set symbol as first bit");

    got_done = 0; got_err = 0;
    send_msg(1, 64'h2, 2); drive(1, 12); drive(0, 10); stop_idle();
    expect_bad("R2 width outside every window");

    got_done = 0; got_err = 0;
    send_msg(1, 64'h9, 4); drive(1, 8); drive(0, 79); drive(1, 8); drive(0, 100);
    expect_bad("R8 space one short of idle");

    ft_cfg = mk_ft(63, 5, 10);
    run_ok(1, 64'h6, 4, 64'h6, "R9 odd minimum rounds down");
    ft_cfg = mk_ft(63, 10, 10);
    got_done = 0; got_err = 0;
    send_msg(1, 64'h81, 8); stop_idle();
    expect_bad("R9 below minimum length");
    ft_cfg = mk_ft(9, 4, 10);
    run_ok(1, 64'h2AA, 10, 64'h2AA, "R9 odd maximum rounds up");
    got_done = 0; got_err = 0;
    send_msg(1, 64'h555, 11); stop_idle();
    expect_bad("R9 above maximum length");
    ft_cfg = mk_ft(63, 31, 10);
    run_ok(1, 64'h2AAA_AAAA, 30, 64'h2AAA_AAAA, "R9 minimum capped at 30");
    ft_cfg = mk_ft(63, 4, 10);

    got_done = 0; got_err = 0;
    send_msg(1, 64'h5, 3);
    ctrl = 5'b00010; repeat (5) @(posedge clk); #1;
    ctrl = 5'b00011;
    stop_idle();
    chk(got_done == 0 && got_err == 0, "R10 disable drops message", 64'(got_done + got_err), 64'd0);
    chk(rx_data == last_data, "R10 capture untouched", rx_data, last_data);

    run_ok(1, 64'hC3, 8, 64'hC3, "R8 R12 recovery frame");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule